// File: doc/BRIEF.md
# Predicated Compare-Subtract Execution Unit

A small single-issue execution unit in which every 32-bit instruction carries a condition code. The instruction takes effect only when its condition holds against the flags that the most recent compare left behind. Four operations are provided: a compare that sets flags, a predicated subtract, a predicated add whose second operand is shifted left by an immediate, and a predicated PC-relative branch. A halt encoding is also provided. Because predication applies to every instruction, the two arms of an if/else inside a loop run as straight-line code with no branch around them.

The unit has a 16-entry register file, a flag register, condition evaluation, a barrel shifter and a small instruction memory. While execution is stopped, a load port writes the instruction memory or the register file. A read port shows any register. With `run` high, one instruction retires per clock until a halt executes.

Top module: `pred_exec_unit`

## Requirements
- R1: After reset, `pc` is 0, `flags` is 0, `halted` is 0 and every register reads 0.
- R2: The instruction fields are cond [31:28], opcode [27:24], rd [23:20], rn [19:16], rm [15:12] and shift amount k [4:0]. The opcodes are 0 compare, 1 subtract, 2 add-shifted, 3 branch and 4 halt. Any other opcode only advances the PC.
- R3: A compare sets `flags` = {N,Z,C,V} from rn − rm. N is bit 31 of the difference, Z means the difference is zero, C means no unsigned borrow, and V means signed overflow. A compare writes no register.
- R4: The condition codes are 0 EQ (Z), 1 NE (!Z), 2 LT (N≠V), 3 GT (!Z and N=V), 4 LE (Z or N≠V), 5 GE (N=V) and 14 always. Codes 6–13 and 15 never pass.
- R5: A subtract whose condition passes writes rd = rn − rm, modulo 2^32.
- R6: An add-shifted whose condition passes writes rd = rn + (rm << k), modulo 2^32.
- R7: A branch whose condition passes sets pc = pc + sign-extended imm[23:0], modulo the memory depth. A branch whose condition fails moves to pc + 1.
- R8: An instruction whose condition fails takes one cycle, advances pc by 1, writes no register and leaves the flags unchanged.
- R9: Only a compare changes `flags`. Subtracts, adds, branches and halts leave them unchanged.
- R10: A halt whose condition passes sets `halted` and holds `pc` at the halt. No further instruction executes until reset.
- R11: No instruction executes while `run` is low or `ld_en` is high. With `ld_en` high, `ld_data` is written to the register file when `ld_to_rf` is 1 (index ld_addr[3:0]) and to instruction memory when it is 0.
- R12: The program compare r1,r2; GT subtract r1=r1−r2; LT subtract r2=r2−r1; NE branch −3; halt leaves gcd(a,b) in both r1 and r2 for positive starting values a and b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Execute one instruction per cycle while high |
| ld_en | input | 1 | Load strobe for memory or register file |
| ld_to_rf | input | 1 | 1 selects the register file, 0 the instruction memory |
| ld_addr | input | PC_W | Load address |
| ld_data | input | 32 | Load data |
| rd_sel | input | 4 | Register read selector |
| rd_data | output | 32 | Contents of the selected register |
| pc | output | PC_W | Program counter |
| flags | output | 4 | {N,Z,C,V} |
| halted | output | 1 | Halt has executed |

## Verification
The bench targets signed comparison across the sign boundary: a compare of 0x80000000 with 1 must give LT. A unit that took GT and LT from unsigned carry would choose the wrong arm there. Every condition code is tried against less-than, equal and greater-than operands, so an inverted LE or GE, or an EQ-only LE, gives a wrong marker register. Subtracts that yield negative results, followed by the flag readout, catch a unit that lets arithmetic touch the flags. Forward and backward branches, skipped markers, and GCD runs with equal, coprime and random operands catch a wrong offset, a wrong fall-through, or a suppressed instruction that still writes.

// File: rtl/peu_pkg.sv
package peu_pkg;
  localparam int DATA_W  = 32;
  localparam int INSN_W  = 32;
  localparam int REG_AW  = 4;
  localparam int NREGS   = 1 << REG_AW;
  localparam int SHAMT_W = $clog2(DATA_W);

  typedef enum logic [3:0] {
    OP_CMP = 4'd0, OP_SUB = 4'd1, OP_ADDSH = 4'd2, OP_BR = 4'd3, OP_HALT = 4'd4
  } op_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0, CC_NE = 4'd1, CC_LT = 4'd2, CC_GT = 4'd3,
    CC_LE = 4'd4, CC_GE = 4'd5, CC_AL = 4'd14
  } cc_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  function automatic flags_t cmp_flags(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    logic [DATA_W:0] d;
    flags_t f;
    d   = {1'b0, a} - {1'b0, b};
    f.n = d[DATA_W-1];
    f.z = (d[DATA_W-1:0] == '0);
    f.c = ~d[DATA_W];
    f.v = (a[DATA_W-1] != b[DATA_W-1]) && (d[DATA_W-1] != a[DATA_W-1]);
    return f;
  endfunction

  function automatic logic cond_pass(input logic [3:0] cc, input flags_t f);
    logic ok;
    case (cc)
      CC_EQ:   ok = f.z;
      CC_NE:   ok = ~f.z;
      CC_LT:   ok = (f.n != f.v);
      CC_GT:   ok = ~f.z && (f.n == f.v);
      CC_LE:   ok = f.z || (f.n != f.v);
      CC_GE:   ok = (f.n == f.v);
      CC_AL:   ok = 1'b1;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic [DATA_W-1:0] sub_res(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    return a - b;
  endfunction

  function automatic logic [DATA_W-1:0] addsh_res(input logic [DATA_W-1:0] a,
                                                  input logic [DATA_W-1:0] b,
                                                  input logic [SHAMT_W-1:0] k);
    return a + (b << k);
  endfunction
endpackage

// File: rtl/peu_regfile.sv
module peu_regfile
  import peu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [REG_AW-1:0] ra,
  input  logic [REG_AW-1:0] rb,
  input  logic [REG_AW-1:0] rc,
  output logic [DATA_W-1:0] qa,
  output logic [DATA_W-1:0] qb,
  output logic [DATA_W-1:0] qc
);
  logic [DATA_W-1:0] regs [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                  regs[i] <= '0;
      else if (we && (waddr == REG_AW'(i)))        regs[i] <= wdata;
    end
  end

  assign qa = regs[ra];
  assign qb = regs[rb];
  assign qc = regs[rc];
endmodule

// File: rtl/peu_imem.sv
module peu_imem
  import peu_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [INSN_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [INSN_W-1:0] rdata
);
  logic [INSN_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/peu_exec.sv
module peu_exec
  import peu_pkg::*;
#(
  parameter int PC_W = 5
) (
  input  logic              step,
  input  logic [INSN_W-1:0] insn,
  input  logic [PC_W-1:0]   pc,
  input  flags_t            flags,
  input  logic [DATA_W-1:0] rn_val,
  input  logic [DATA_W-1:0] rm_val,
  output logic              cond_ok,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              flag_we,
  output flags_t            flags_next,
  output logic              br_taken,
  output logic              halt_fire,
  output logic [PC_W-1:0]   pc_next
);
  logic          act;
  logic [3:0]    op;
  logic [PC_W-1:0] br_off;
  logic          unused_bits;

  assign op          = insn[27:24];
  assign cond_ok     = cond_pass(insn[31:28], flags);
  assign act         = step && cond_ok;
  assign br_off      = insn[PC_W-1:0];
  assign flags_next  = cmp_flags(rn_val, rm_val);
  assign unused_bits = ^insn;

  always_comb begin
    wr_en     = 1'b0;
    wr_data   = sub_res(rn_val, rm_val);
    flag_we   = 1'b0;
    br_taken  = 1'b0;
    halt_fire = 1'b0;
    case (op)
      OP_CMP:   flag_we   = act;
      OP_SUB:   wr_en     = act;
      OP_ADDSH: begin
        wr_en   = act;
        wr_data = addsh_res(rn_val, rm_val, insn[SHAMT_W-1:0]);
      end
      OP_BR:    br_taken  = act;
      OP_HALT:  halt_fire = act;
      default:  ;
    endcase
  end

  always_comb begin
    if (halt_fire)     pc_next = pc;
    else if (br_taken) pc_next = pc + br_off;
    else               pc_next = pc + 1'b1;
  end
endmodule

// File: rtl/pred_exec_unit.sv
module pred_exec_unit
  import peu_pkg::*;
#(
  parameter int IMEM_DEPTH = 32,
  localparam int PC_W = $clog2(IMEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ld_en,
  input  logic              ld_to_rf,
  input  logic [PC_W-1:0]   ld_addr,
  input  logic [31:0]       ld_data,
  input  logic [3:0]        rd_sel,
  output logic [31:0]       rd_data,
  output logic [PC_W-1:0]   pc,
  output logic [3:0]        flags,
  output logic              halted
);
  logic [INSN_W-1:0] insn;
  logic [DATA_W-1:0] rn_val, rm_val;
  logic              step, cond_ok, wr_en, flag_we, br_taken, halt_fire;
  logic [DATA_W-1:0] wr_data;
  flags_t            flags_q, flags_next;
  logic [PC_W-1:0]   pc_q, pc_next;
  logic              halted_q;
  logic              rf_we;
  logic [REG_AW-1:0] rf_waddr;
  logic [DATA_W-1:0] rf_wdata;

  assign step = run && !ld_en && !halted_q;

  peu_imem #(.DEPTH(IMEM_DEPTH)) u_imem (
    .clk(clk), .we(ld_en && !ld_to_rf), .waddr(ld_addr), .wdata(ld_data),
    .raddr(pc_q), .rdata(insn)
  );

  assign rf_we    = (ld_en && ld_to_rf) || wr_en;
  assign rf_waddr = ld_en ? ld_addr[REG_AW-1:0] : insn[23:20];
  assign rf_wdata = ld_en ? ld_data : wr_data;

  peu_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra(insn[19:16]), .rb(insn[15:12]), .rc(rd_sel),
    .qa(rn_val), .qb(rm_val), .qc(rd_data)
  );

  peu_exec #(.PC_W(PC_W)) u_exec (
    .step(step), .insn(insn), .pc(pc_q), .flags(flags_q),
    .rn_val(rn_val), .rm_val(rm_val), .cond_ok(cond_ok),
    .wr_en(wr_en), .wr_data(wr_data), .flag_we(flag_we), .flags_next(flags_next),
    .br_taken(br_taken), .halt_fire(halt_fire), .pc_next(pc_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= '0;
      flags_q  <= '0;
      halted_q <= 1'b0;
    end else begin
      if (step)      pc_q     <= pc_next;
      if (flag_we)   flags_q  <= flags_next;
      if (halt_fire) halted_q <= 1'b1;
    end
  end

  assign pc     = pc_q;
  assign flags  = flags_q;
  assign halted = halted_q;
endmodule

// File: rtl/peu_checker.sv
module peu_checker #(
  parameter int PC_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            step,
  input logic            ld_en,
  input logic            cond_ok,
  input logic [3:0]      op,
  input logic            wr_en,
  input logic            flag_we,
  input logic            br_taken,
  input logic            halt_fire,
  input logic [PC_W-1:0] pc,
  input logic [3:0]      flags,
  input logic            halted
);
  logic [PC_W-1:0] pc_inc;
  assign pc_inc = pc + 1'b1;

  AST_SUPPRESSED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cond_ok) |-> (!wr_en && !flag_we && !br_taken && !halt_fire)); // R8
  AST_SUPPRESSED_PC_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cond_ok) |=> (pc == $past(pc_inc))); // R8
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags)); // R9
  AST_FLAGS_FROM_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (step && op == 4'd0)); // R9
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc))); // R10
  AST_IDLE_PC: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc)); // R11
  AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |-> !step); // R11
  AST_ONE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, flag_we, br_taken, halt_fire})); // R2
endmodule

bind pred_exec_unit peu_checker #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .ld_en(ld_en), .cond_ok(cond_ok),
  .op(insn[27:24]), .wr_en(wr_en), .flag_we(flag_we), .br_taken(br_taken),
  .halt_fire(halt_fire), .pc(pc), .flags(flags), .halted(halted)
);

// File: tb/tb_pred_exec_unit.sv
module tb_pred_exec_unit;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0, run = 1'b0, ld_en = 1'b0, ld_to_rf = 1'b0;
  logic [PC_W-1:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [3:0] rd_sel = '0;
  logic [31:0] rd_data;
  logic [PC_W-1:0] pc;
  logic [3:0] flags;
  logic halted;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_exec_unit #(.IMEM_DEPTH(32)) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .ld_en(ld_en), .ld_to_rf(ld_to_rf),
    .ld_addr(ld_addr), .ld_data(ld_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .pc(pc), .flags(flags), .halted(halted)
  );

  function automatic logic [31:0] enc(int cc, int op, int rd, int rn, int rm, int k);
    return {cc[3:0], op[3:0], rd[3:0], rn[3:0], rm[3:0], 7'd0, k[4:0]};
  endfunction
  function automatic logic [31:0] enc_br(int cc, int off);
    return {cc[3:0], 4'd3, off[23:0]};
  endfunction
  function automatic logic [31:0] halt_i();
    return {4'd14, 4'd4, 24'd0};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; run = 0; ld_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic ld(bit to_rf, int addr, logic [31:0] data);
    ld_en = 1; ld_to_rf = to_rf; ld_addr = addr[PC_W-1:0]; ld_data = data;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic rdreg(int idx, output logic [31:0] v);
    rd_sel = idx[3:0];
    #1 v = rd_data;
  endtask

  task automatic run_to_halt(string req, int limit);
    int n = 0;
    run = 1;
    while (!halted && n < limit) begin
      @(negedge clk);
      n++;
    end
    run = 0;
    chk({req, " halted"}, {31'd0, halted}, 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    chk("R1 pc", {27'd0, pc}, 0);
    chk("R1 flags", {28'd0, flags}, 0);
    chk("R1 halted", {31'd0, halted}, 0);
    for (int i = 0; i < 16; i++) begin
      rdreg(i, v);
      chk("R1 reg", v, 0);
    end
  endtask

  task automatic t_cmp(logic [31:0] a, logic [31:0] b, logic [3:0] exp);
    logic [31:0] v;
    do_reset();
    ld(1, 1, a); ld(1, 2, b); ld(1, 3, 32'h55);
    ld(0, 0, enc(14, 0, 3, 1, 2, 0));
    ld(0, 1, halt_i());
    run_to_halt("R3", 20);
    chk("R3 flags", {28'd0, flags}, {28'd0, exp});
    rdreg(3, v);
    chk("R3 no write", v, 32'h55);
  endtask

  // R4: one marker register per condition code
  task automatic t_cond(logic [31:0] a, logic [31:0] b);
    int ccs[8] = '{0, 1, 2, 3, 4, 5, 14, 15};
    logic [31:0] v;
    bit eq, lt, gt, e;
    eq = (a == b); lt = ($signed(a) < $signed(b)); gt = !eq && !lt;
    do_reset();
    ld(1, 1, a); ld(1, 2, b); ld(1, 3, 1);
    ld(0, 0, enc(14, 0, 0, 1, 2, 0));
    for (int i = 0; i < 8; i++) ld(0, i + 1, enc(ccs[i], 2, 4 + i, 0, 3, 0));
    ld(0, 9, halt_i());
    run_to_halt("R4", 40);
    for (int i = 0; i < 8; i++) begin
      case (ccs[i])
        0: e = eq;  1: e = !eq;  2: e = lt;  3: e = gt;
        4: e = eq || lt;  5: e = !lt;  14: e = 1;  default: e = 0;
      endcase
      rdreg(4 + i, v);
      chk($sformatf("R4 cc%0d", ccs[i]), v, {31'd0, e});
    end
  endtask

  task automatic t_sub();
    logic [31:0] v;
    do_reset();
    ld(1, 1, 20); ld(1, 2, 6); ld(1, 4, 99);
    ld(0, 0, enc(14, 0, 0, 1, 2, 0));
    ld(0, 1, enc(3, 1, 3, 1, 2, 0));
    ld(0, 2, enc(4, 1, 4, 1, 2, 0));
    ld(0, 3, enc(14, 1, 5, 2, 1, 0));
    ld(0, 4, halt_i());
    run_to_halt("R5", 20);
    rdreg(3, v); chk("R5 GT sub", v, 14);
    rdreg(4, v); chk("R5 LE suppressed", v, 99);
    rdreg(5, v); chk("R5 negative wrap", v, 32'hFFFF_FFF2);
    chk("R9 flags after sub", {28'd0, flags}, 4'b0010);
  endtask

  task automatic t_addsh();
    logic [31:0] v;
    do_reset();
    ld(1, 1, 10); ld(1, 2, 3); ld(1, 6, 32'hFFFF_FFFF); ld(1, 7, 1);
    ld(0, 0, enc(14, 0, 0, 1, 2, 0));
    ld(0, 1, enc(14, 2, 3, 1, 2, 4));
    ld(0, 2, enc(14, 2, 4, 1, 2, 0));
    ld(0, 3, enc(14, 2, 5, 1, 2, 31));
    ld(0, 4, enc(14, 2, 8, 6, 7, 0));
    ld(0, 5, halt_i());
    run_to_halt("R6", 20);
    rdreg(3, v); chk("R6 k=4", v, 10 + 16 * 3);
    rdreg(4, v); chk("R6 k=0", v, 13);
    rdreg(5, v); chk("R6 k=31", v, 32'h8000_000A);
    rdreg(8, v); chk("R6 wrap to zero", v, 0);
    chk("R9 flags after add", {28'd0, flags}, 4'b0010);
  endtask

  task automatic t_branch();
    logic [31:0] v;
    do_reset();
    ld(1, 3, 1);
    ld(0, 0, enc_br(14, 3));
    ld(0, 1, enc(14, 2, 5, 0, 3, 0));
    ld(0, 3, enc(14, 0, 0, 1, 1, 0));
    ld(0, 4, enc_br(1, 5));
    ld(0, 5, enc_br(0, 2));
    ld(0, 6, enc(14, 2, 6, 0, 3, 0));
    ld(0, 7, halt_i());
    run_to_halt("R7", 20);
    chk("R7 final pc", {27'd0, pc}, 7);
    rdreg(5, v); chk("R7 forward skip", v, 0);
    rdreg(6, v); chk("R7 EQ taken skip", v, 0);
  endtask

  task automatic t_step();
    logic [31:0] v;
    do_reset();
    ld(1, 1, 5); ld(1, 2, 5); ld(1, 3, 77);
    ld(0, 0, enc(14, 0, 0, 1, 2, 0));
    ld(0, 1, enc(3, 1, 3, 1, 2, 0));
    ld(0, 2, {4'd15, 4'd4, 24'd0});
    ld(0, 3, halt_i());
    repeat (3) @(negedge clk);
    chk("R11 idle pc", {27'd0, pc}, 0);
    run = 1; ld_en = 1; ld_to_rf = 1; ld_addr = 9; ld_data = 32'h1234;
    @(negedge clk);
    ld_en = 0;
    chk("R11 load stalls pc", {27'd0, pc}, 0);
    rdreg(9, v); chk("R11 reg load", v, 32'h1234);
    @(negedge clk);
    run = 0;
    chk("R8 pc after cmp", {27'd0, pc}, 1);
    chk("R3 equal flags", {28'd0, flags}, 4'b0110);
    run = 1; @(negedge clk); run = 0;
    chk("R8 suppressed pc", {27'd0, pc}, 2);
    rdreg(3, v); chk("R8 suppressed no write", v, 77);
    chk("R8 flags unchanged", {28'd0, flags}, 4'b0110);
    run = 1; @(negedge clk); run = 0;
    chk("R10 never-halt passes", {27'd0, pc}, 3);
    chk("R10 not halted", {31'd0, halted}, 0);
    run = 1; @(negedge clk);
    repeat (3) @(negedge clk);
    run = 0;
    chk("R10 halted", {31'd0, halted}, 1);
    chk("R10 pc held", {27'd0, pc}, 3);
  endtask

  function automatic int ref_gcd(int a, int b);
    int t;
    while (b != 0) begin t = a % b; a = b; b = t; end
    return a;
  endfunction

  task automatic t_gcd(int a, int b);
    logic [31:0] v;
    int g;
    g = ref_gcd(a, b);
    do_reset();
    ld(1, 1, a); ld(1, 2, b);
    ld(0, 0, enc(14, 0, 0, 1, 2, 0));
    ld(0, 1, enc(3, 1, 1, 1, 2, 0));
    ld(0, 2, enc(2, 1, 2, 2, 1, 0));
    ld(0, 3, enc_br(1, -3));
    ld(0, 4, halt_i());
    run_to_halt("R12", 8000);
    rdreg(1, v); chk($sformatf("R12 gcd(%0d,%0d) r1", a, b), v, g);
    rdreg(2, v); chk($sformatf("R12 gcd(%0d,%0d) r2", a, b), v, g);
    chk("R12 halt pc", {27'd0, pc}, 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_cmp(5, 9, 4'b1000);
    t_cmp(9, 5, 4'b0010);
    t_cmp(7, 7, 4'b0110);
    t_cmp(32'h8000_0000, 1, 4'b0011);
    t_cond(3, 7);
    t_cond(5, 5);
    t_cond(7, 3);
    t_cond(32'h8000_0000, 1);
    t_sub();
    t_addsh();
    t_branch();
    t_step();
    t_gcd(48, 18);
    t_gcd(7, 7);
    t_gcd(1, 13);
    t_gcd(17, 256);
    for (int i = 0; i < 6; i++) t_gcd(1 + ($urandom % 400), 1 + ($urandom % 400));
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule